// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory and writeback. The register file is read in decode and written in writeback, so the only ordering problem left between instructions is a true read-after-write dependence. Forwarding paths cover almost all of these dependences.

One case cannot be forwarded. A load in execute produces its value only at the end of the memory stage, so an instruction that reads that value in the very next slot has to wait. For that case the unit freezes the program counter and the fetch/decode register for one cycle and asks for a no-op to be placed into the decode/execute register. After that one bubble, the dependent instruction and any later readers of the loaded register get the value through forwarding.

Sources are checked only when the decoded instruction really reads them. Register zero is hard-wired to zero and never creates a dependence. When a branch flush is requested in the same cycle, the stall request is dropped.

Top module: `load_use_stall`

## Requirements
- R1: When the execute stage holds a load whose destination is non-zero and equal to a used decode source, the unit stalls in the same cycle: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1.
- R2: Each source operand slot can trigger the stall on its own. Slot k sits at bits [k*REG_IDX_W +: REG_IDX_W] of `id_src_idx` and its use flag is bit k of `id_src_used`.
- R3: A source whose use flag is 0 never causes a stall, even when its register number matches the load destination.
- R4: A load whose destination is register 0 never causes a stall.
- R5: When `ex_is_load` is 0, nothing stalls, whatever the register numbers are.
- R6: When `flush_req` is 1, the outputs are `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0, even if a stall condition holds.
- R7: With no stall condition, `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0.
- R8: `pc_we` and `ifid_we` are always equal, and `idex_bubble` is always their inverse.
- R9: While `rst_n` is 0, the unit reports no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_idx | input | NUM_SRC*REG_IDX_W | Decode-stage source register numbers, slot 0 in the low bits |
| id_src_used | input | NUM_SRC | Per-slot flag: decoded instruction reads this source |
| ex_rd_idx | input | REG_IDX_W | Destination register of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| flush_req | input | 1 | Branch flush this cycle; overrides the stall |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Insert a no-op into the decode/execute register |

## Verification
The unit is purely combinational from inputs to outputs, so any wrong decision appears at the ports in the same cycle as the input pattern that caused it. There is no delayed symptom to chase. A missed stall shows as `idex_bubble` low with both enables high while a used source matches a non-zero load destination. A spurious stall shows as a frozen PC when the source is unused, when the destination is register zero, when no load is in execute, or when a flush is present. Comparing the three outputs every cycle against an independent model therefore exposes every fault on the first cycle in which it matters.

// File: rtl/lu_hazard_pkg.sv
// Package: shared widths and the stall decision encoding for the
// load-use hazard unit. Assumes a register file of 2**REG_IDX_W entries
// with entry 0 hard-wired to zero.
package lu_hazard_pkg;

    // Decision taken by the stall controller in a given cycle
    typedef enum logic [1:0] {
        HZ_RUN   = 2'd0,   // no hazard, pipeline advances
        HZ_STALL = 2'd1,   // hold PC and IF/ID, bubble into ID/EX
        HZ_FLUSH = 2'd2,   // flush wins over a stall request
        HZ_RESET = 2'd3    // reset held, report no stall
    } hz_action_e;

endpackage

// File: rtl/lu_src_match.sv
// Module: lu_src_match
// Compares one decode-stage source operand with the execute-stage
// destination. Raises hit only when the execute stage holds a load, the
// source is really read, and the register is not register zero.
// Assumes REG_IDX_W-bit register numbers.
module lu_src_match #(
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic                 src_used,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic                 dst_is_load,
    output logic                 hit
);

    localparam logic [REG_IDX_W-1:0] ZERO_REG = '0;

    logic same_reg;
    logic dst_live;

    // Register number equality and zero-register exclusion
    always_comb begin
        same_reg = (src_idx == dst_idx);
        dst_live = (dst_idx != ZERO_REG);
    end

    // Final per-operand hazard flag
    always_comb begin
        hit = dst_is_load && src_used && same_reg && dst_live;
    end

endmodule

// File: rtl/lu_stall_ctrl.sv
// Module: lu_stall_ctrl
// Merges per-operand hits into one decision, applies reset and flush
// priority, and drives the three pipeline control outputs.
// Assumes the flush logic elsewhere clears IF/ID and ID/EX itself.
module lu_stall_ctrl
    import lu_hazard_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit_vec,
    input  logic               flush_req,
    output hz_action_e         action,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               idex_bubble
);

    logic any_hit;

    // Reduce the per-operand hits
    always_comb begin
        any_hit = |hit_vec;
    end

    // Priority: reset, then flush, then stall, else run
    always_comb begin
        if (!rst_n)         action = HZ_RESET;
        else if (flush_req) action = HZ_FLUSH;
        else if (any_hit)   action = HZ_STALL;
        else                action = HZ_RUN;
    end

    // Decode the action into the pipeline enables
    always_comb begin
        case (action)
            HZ_STALL: begin
                pc_we       = 1'b0;
                ifid_we     = 1'b0;
                idex_bubble = 1'b1;
            end
            default: begin
                pc_we       = 1'b1;
                ifid_we     = 1'b1;
                idex_bubble = 1'b0;
            end
        endcase
    end

    // R6: a flush never leaves the front end frozen
    p_flush_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (pc_we && ifid_we && !idex_bubble));

    // R8: the enables and the bubble strobe always agree
    p_ctrl_consistent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (idex_bubble == !pc_we));

    // R1: any operand hit without a flush stalls the front end
    p_hit_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_vec != '0) && !flush_req) |-> (!pc_we && idex_bubble));

endmodule

// File: rtl/load_use_stall.sv
// Module: load_use_stall (top)
// Detects a load in execute whose result is needed by the instruction in
// decode and requests a single-cycle stall with a bubble. All other
// read-after-write cases are assumed to be covered by forwarding.
// Assumes source slot k occupies id_src_idx[k*REG_IDX_W +: REG_IDX_W].
module load_use_stall
    import lu_hazard_pkg::*;
#(
    parameter int REG_IDX_W = 5,
    parameter int NUM_SRC   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC*REG_IDX_W-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]           id_src_used,
    input  logic [REG_IDX_W-1:0]         ex_rd_idx,
    input  logic                         ex_is_load,
    input  logic                         flush_req,
    output logic                         pc_we,
    output logic                         ifid_we,
    output logic                         idex_bubble
);

    logic [NUM_SRC-1:0] hit_vec;
    hz_action_e         action;

    // One comparator per source operand slot
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        lu_src_match #(
            .REG_IDX_W (REG_IDX_W)
        ) i_match (
            .src_idx     (id_src_idx[k*REG_IDX_W +: REG_IDX_W]),
            .src_used    (id_src_used[k]),
            .dst_idx     (ex_rd_idx),
            .dst_is_load (ex_is_load),
            .hit         (hit_vec[k])
        );

        // R3: an unread operand slot never produces a hit
        p_unused_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !id_src_used[k] |-> !hit_vec[k]);
    end

    lu_stall_ctrl #(
        .NUM_SRC (NUM_SRC)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_vec     (hit_vec),
        .flush_req   (flush_req),
        .action      (action),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .idex_bubble (idex_bubble)
    );

    // R4: a load into register zero never stalls
    p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd_idx == '0) |-> !idex_bubble);

    // R5: no load in execute means no stall
    p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> (pc_we && !idex_bubble));

    // R9: a bubble is only ever requested outside reset
    p_reset_quiet_r9: assert property (@(posedge clk)
        idex_bubble |-> rst_n);

endmodule

// File: tb/test_load_use_stall.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module test_load_use_stall;

    localparam int W = 5;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N*W-1:0] id_src_idx;
    logic [N-1:0]   id_src_used;
    logic [W-1:0]   ex_rd_idx;
    logic           ex_is_load;
    logic           flush_req;
    logic           pc_we, ifid_we, idex_bubble;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    load_use_stall #(.REG_IDX_W(W), .NUM_SRC(N)) i_load_use_stall (
        .clk(clk), .rst_n(rst_n), .id_src_idx(id_src_idx),
        .id_src_used(id_src_used), .ex_rd_idx(ex_rd_idx),
        .ex_is_load(ex_is_load), .flush_req(flush_req),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
    );

    // Reference: does this input pattern call for a stall?
    function automatic bit model_stall(bit rst, int s0, int s1, bit u0, bit u1,
                                       int rd, bit ld, bit fl);
        if (!rst || fl || !ld || rd == 0) return 1'b0;
        if (u0 && s0 == rd) return 1'b1;
        if (u1 && s1 == rd) return 1'b1;
        return 1'b0;
    endfunction

    // Apply one vector just after a rising edge, check at the falling edge
    task automatic apply(input bit rst, input int s0, input int s1,
                         input bit u0, input bit u1, input int rd,
                         input bit ld, input bit fl, input string tag);
        bit exp_stall;
        @(posedge clk); #1;
        rst_n       = rst;
        id_src_idx  = {s1[W-1:0], s0[W-1:0]};
        id_src_used = {u1, u0};
        ex_rd_idx   = rd[W-1:0];
        ex_is_load  = ld;
        flush_req   = fl;
        exp_stall   = model_stall(rst, s0, s1, u0, u1, rd, ld, fl);
        @(negedge clk);
        checks++;
        if (pc_we !== !exp_stall || ifid_we !== !exp_stall ||
            idex_bubble !== exp_stall) begin
            errors++;
            $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected %b %b %b",
                     tag, pc_we, ifid_we, idex_bubble,
                     !exp_stall, !exp_stall, exp_stall);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        rst_n = 1'b0; id_src_idx = '0; id_src_used = '0;
        ex_rd_idx = '0; ex_is_load = 1'b0; flush_req = 1'b0;
        // R9: reset held while a real hazard is present
        apply(0, 7, 0, 1, 0, 7, 1, 0, "R9");
        apply(0, 3, 3, 1, 1, 3, 1, 0, "R9");
        // R7: idle pipeline
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R1 / R2: slot 0 match, then slot 1 match, then both
        apply(1, 9, 4, 1, 1, 9, 1, 0, "R1");
        apply(1, 4, 9, 1, 1, 9, 1, 0, "R2");
        apply(1, 9, 9, 1, 1, 9, 1, 0, "R2");
        apply(1, 31, 2, 1, 0, 31, 1, 0, "R1");
        // R7: no match, next cycle after a stall releases
        apply(1, 5, 6, 1, 1, 9, 1, 0, "R7");
        // R3: matching but unread operands
        apply(1, 9, 4, 0, 1, 9, 1, 0, "R3");
        apply(1, 4, 9, 1, 0, 9, 1, 0, "R3");
        // R4: load into register zero with matching used sources
        apply(1, 0, 0, 1, 1, 0, 1, 0, "R4");
        // R5: non-load producer with a matching source
        apply(1, 12, 12, 1, 1, 12, 0, 0, "R5");
        // R6: flush alongside a genuine hazard
        apply(1, 12, 1, 1, 1, 12, 1, 1, "R6");
        apply(1, 12, 1, 1, 1, 12, 1, 0, "R1");
        // R8 and general mix: biased random patterns
        for (int i = 0; i < 400; i++) begin
            apply(1, $urandom_range(0, 3), $urandom_range(0, 3),
                  1'($urandom), 1'($urandom), $urandom_range(0, 3),
                  1'($urandom), ($urandom_range(0, 7) == 0), "R8");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule